// File: doc/BRIEF.md
# Tagged Sample FIFO with Threshold Interrupt

This block is the buffer between an acquisition sequencer and a host bus. The sequencer pushes 16-bit samples into a 512-entry first-in first-out store. Each sample carries a 5-bit channel number. The host drains the samples either with one 16-bit read or with two byte reads. In byte mode only the upper-byte read removes the sample, so the host can read the lower byte first without losing it.

A status word combines three things: the live fill count, the channel number of the entry at the head, and an interrupt-enable bit. The same status word also takes a write-only threshold. The level interrupt is high while the enable bit is set and the fill count is at or above that threshold. The threshold resets to half the depth.

The sequencer sees a full flag, and any push that arrives while the store is full is dropped. A flush input empties the store in one cycle.

Top module: `tagged_sample_fifo`

## Requirements
- R1: After reset the fill count is 0, the enable bit is 0, `irq` and `full` are low, `rd_data` is 0, and the threshold is DEPTH/2 (256).
- R2: A push stores the sample and its channel in arrival order and raises the fill count by one. `stat_rdata` packs the count in bits 15:6, the head channel in bits 5:1 and the enable bit in bit 0.
- R3: A word-read strobe loads the head sample into `rd_data` at the next edge and pops the entry. When strobes coincide, word beats high byte, and high byte beats low byte.
- R4: A low-byte strobe loads `{8'h00, head[7:0]}` into `rd_data` and leaves the store and the count unchanged.
- R5: A high-byte strobe loads `{8'h00, head[15:8]}` into `rd_data` and pops the entry.
- R6: The head-channel field always equals the channel pushed with the sample now at the head.
- R7: `full` is high exactly when the count equals DEPTH (512). A push while full is dropped.
- R8: A read while empty returns data from the last popped sample, reports that sample's channel, and leaves the count at 0.
- R9: A status write with mask bit 0 set loads the enable from data bit 0. A status write with mask bit 1 set loads the threshold from data bits 15:6. `irq` is high exactly when the enable is 1 and count >= threshold, threshold 0 included.
- R10: A flush sets the count to 0 at the next edge and takes priority over a push or pop in the same cycle.
- R11: A push and a pop in the same cycle, with the store neither empty nor full, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Push strobe from the sequencer |
| push_data | input | DATA_W (16) | Sample to store |
| push_tag | input | TAG_W (5) | Channel number of the sample |
| full | output | 1 | Store holds DEPTH entries |
| flush | input | 1 | Empty the store |
| rd_word | input | 1 | 16-bit read strobe (pops) |
| rd_lo | input | 1 | Low-byte read strobe (no pop) |
| rd_hi | input | 1 | High-byte read strobe (pops) |
| rd_data | output | DATA_W (16) | Registered read result |
| stat_wr | input | 1 | Status write strobe |
| stat_wmask | input | 2 | Bit 0: update enable, bit 1: update threshold |
| stat_wdata | input | STAT_W (16) | Status write data |
| stat_rdata | output | STAT_W (16) | {count, head channel, enable} |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a depth of 512, 16-bit samples and 5-bit tags. With these values the half-full default threshold of 256 is checked as a real crossing. A completely full store is reached in about 512 pushes, so the dropped push and the full flag are exercised at the true depth. The threshold is also moved to 511, 512 and above the depth, and set to 0, which covers the equality boundaries of the compare.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_WORD = 2'd1,
        RD_LO   = 2'd2,
        RD_HI   = 2'd3
    } rd_op_e;

    // Word beats high byte, high byte beats low byte.
    function automatic rd_op_e decode_rd(input logic word, input logic lo, input logic hi);
        if (word)    return RD_WORD;
        else if (hi) return RD_HI;
        else if (lo) return RD_LO;
        else         return RD_NONE;
    endfunction

    function automatic logic op_pops(input rd_op_e op);
        return (op == RD_WORD) || (op == RD_HI);
    endfunction

endpackage

// File: rtl/tsf_storage.sv
module tsf_storage #(
    parameter int DEPTH = 512,
    parameter int ENT_W = 21,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);

    logic [ENT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ENT_W = DATA_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              pop_req,
    input  logic              flush,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_waddr,
    output logic [ENT_W-1:0]  mem_wdata,
    output logic [PTR_W-1:0]  mem_raddr,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic [CNT_W-1:0]  count,
    output logic              full
);

    typedef struct packed {
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [CNT_W-1:0]  count;
        logic [DATA_W-1:0] last_data;
        logic [TAG_W-1:0]  last_tag;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic empty, do_push, do_pop;

    always_comb begin
        empty   = (st_q.count == '0);
        full    = (st_q.count == CNT_W'(DEPTH));
        do_push = push && !full && !flush;
        do_pop  = pop_req && !empty && !flush;

        st_d = st_q;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (do_push) begin
                st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd_ptr    = st_q.rd_ptr + 1'b1;
                st_d.last_data = mem_rdata[DATA_W-1:0];
                st_d.last_tag  = mem_rdata[ENT_W-1:DATA_W];
            end
            st_d.count = st_q.count + CNT_W'(do_push) - CNT_W'(do_pop);
        end

        mem_we    = do_push;
        mem_waddr = st_q.wr_ptr;
        mem_wdata = {push_tag, push_data};
        mem_raddr = st_q.rd_ptr;
        head_data = empty ? st_q.last_data : mem_rdata[DATA_W-1:0];
        head_tag  = empty ? st_q.last_tag  : mem_rdata[ENT_W-1:DATA_W];
        count     = st_q.count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    // R7
    full_drops_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_req && !flush) |=> (count == CNT_W'(DEPTH)));

    // R11
    push_pop_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop_req && !flush && !empty && !full) |=> $stable(count));

    // R4
    idle_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop_req && !flush) |=> $stable(count));

endmodule

// File: rtl/tsf_host_if.sv
module tsf_host_if
    import tsf_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int STAT_W = CNT_W + TAG_W + 1,
    localparam int HALF   = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_word,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              stat_wr,
    input  logic [1:0]        stat_wmask,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic [DATA_W-1:0] head_data,
    input  logic [TAG_W-1:0]  head_tag,
    input  logic [CNT_W-1:0]  count,
    output logic              pop_req,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              irq_en;
        logic [CNT_W-1:0]  thr;
    } host_state_t;

    host_state_t st_d, st_q;
    rd_op_e      op;
    logic        unused_wbits;

    assign unused_wbits = ^stat_wdata[TAG_W:1];

    always_comb begin
        op      = decode_rd(rd_word, rd_lo, rd_hi);
        pop_req = op_pops(op);

        st_d = st_q;
        unique case (op)
            RD_WORD: st_d.rdata = head_data;
            RD_HI:   st_d.rdata = DATA_W'(head_data[DATA_W-1:HALF]);
            RD_LO:   st_d.rdata = DATA_W'(head_data[HALF-1:0]);
            default: ;
        endcase
        if (stat_wr && stat_wmask[0]) begin
            st_d.irq_en = stat_wdata[0];
        end
        if (stat_wr && stat_wmask[1]) begin
            st_d.thr = stat_wdata[STAT_W-1 -: CNT_W];
        end

        rd_data    = st_q.rdata;
        stat_rdata = {count, head_tag, st_q.irq_en};
        irq        = st_q.irq_en && (count >= st_q.thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdata  <= '0;
            st_q.irq_en <= 1'b0;
            st_q.thr    <= CNT_W'(DEPTH / 2);
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    word_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word |=> (rd_data == $past(head_data)));

    // R4
    lo_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !rd_word && !rd_hi) |=> (rd_data[DATA_W-1:HALF] == '0));

    // R9
    irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wmask[0] && !stat_wdata[0]) |=> !irq);

endmodule

// File: rtl/tagged_sample_fifo.sv
module tagged_sample_fifo #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int STAT_W = CNT_W + TAG_W + 1,
    localparam int ENT_W  = DATA_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [TAG_W-1:0]  push_tag,
    output logic              full,
    input  logic              flush,
    input  logic              rd_word,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stat_wr,
    input  logic [1:0]        stat_wmask,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq
);

    logic              mem_we;
    logic [PTR_W-1:0]  mem_waddr, mem_raddr;
    logic [ENT_W-1:0]  mem_wdata, mem_rdata;
    logic [DATA_W-1:0] head_data;
    logic [TAG_W-1:0]  head_tag;
    logic [CNT_W-1:0]  count;
    logic              pop_req;

    tsf_storage #(.DEPTH(DEPTH), .ENT_W(ENT_W)) storage_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    tsf_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .push_tag  (push_tag),
        .pop_req   (pop_req),
        .flush     (flush),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .head_data (head_data),
        .head_tag  (head_tag),
        .count     (count),
        .full      (full)
    );

    tsf_host_if #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) host_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_word    (rd_word),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi),
        .stat_wr    (stat_wr),
        .stat_wmask (stat_wmask),
        .stat_wdata (stat_wdata),
        .head_data  (head_data),
        .head_tag   (head_tag),
        .count      (count),
        .pop_req    (pop_req),
        .rd_data    (rd_data),
        .stat_rdata (stat_rdata),
        .irq        (irq)
    );

endmodule

// File: tb/tagged_sample_fifo_tb_top.sv
module tagged_sample_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0;
    logic [15:0] push_data = '0;
    logic [4:0]  push_tag = '0;
    logic        full;
    logic        flush = 1'b0;
    logic        rd_word = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
    logic [15:0] rd_data;
    logic        stat_wr = 1'b0;
    logic [1:0]  stat_wmask = '0;
    logic [15:0] stat_wdata = '0;
    logic [15:0] stat_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cnt = 0;

    always #2 clk = ~clk;

    tagged_sample_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .push_tag(push_tag), .full(full), .flush(flush), .rd_word(rd_word),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data), .stat_wr(stat_wr),
        .stat_wmask(stat_wmask), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .irq(irq)
    );

    // {op, data, tag, expected}; op 0 push, 1 word, 2 low byte, 3 high byte
    localparam logic [38:0] VEC [12] = '{
        {2'd0, 16'hA1B2, 5'd3,  16'h0000},
        {2'd0, 16'hC3D4, 5'd4,  16'h0000},
        {2'd0, 16'h00FF, 5'd15, 16'h0000},
        {2'd1, 16'h0000, 5'd3,  16'hA1B2},
        {2'd2, 16'h0000, 5'd4,  16'h00D4},
        {2'd2, 16'h0000, 5'd4,  16'h00D4},
        {2'd3, 16'h0000, 5'd4,  16'h00C3},
        {2'd0, 16'h5555, 5'd0,  16'h0000},
        {2'd1, 16'h0000, 5'd15, 16'h00FF},
        {2'd1, 16'h0000, 5'd0,  16'h5555},
        {2'd1, 16'h0000, 5'd0,  16'h5555},
        {2'd3, 16'h0000, 5'd0,  16'h0055}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_push(input logic [15:0] d, input logic [4:0] t);
        push = 1'b1; push_data = d; push_tag = t;
        step();
        push = 1'b0;
    endtask

    task automatic do_read(input int op);
        rd_word = (op == 1); rd_lo = (op == 2); rd_hi = (op == 3);
        step();
        rd_word = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0;
    endtask

    task automatic stat_write(input logic [1:0] m, input logic [15:0] d);
        stat_wr = 1'b1; stat_wmask = m; stat_wdata = d;
        step();
        stat_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 count", 32'(stat_rdata[15:6]), 0);
        check("R1 enable", 32'(stat_rdata[0]), 0);
        check("R1 irq/full", {30'd0, irq, full}, 0);
        check("R1 rd_data", 32'(rd_data), 0);

        // Vector table: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < 12; i++) begin
            logic [1:0]  op;
            logic [15:0] d, e;
            logic [4:0]  t;
            {op, d, t, e} = VEC[i];
            if (op == 2'd0) begin
                do_push(d, t);
                cnt++;
                check("R2 count after push", 32'(stat_rdata[15:6]), 32'(cnt));
            end else begin
                check("R6 head channel", 32'(stat_rdata[5:1]), 32'(t));
                do_read(int'(op));
                if (op != 2'd2 && cnt > 0) cnt--;
                check(op == 2'd1 ? "R3 word read" : op == 2'd2 ? "R4 low byte" : "R5 high byte",
                      32'(rd_data), 32'(e));
                check(i >= 10 ? "R8 empty count" : "R4 R5 count after read",
                      32'(stat_rdata[15:6]), 32'(cnt));
            end
        end

        // R3 strobe priority: word beats high byte
        do_push(16'h1234, 5'd7);
        rd_word = 1'b1; rd_hi = 1'b1; rd_lo = 1'b1;
        step();
        rd_word = 1'b0; rd_hi = 1'b0; rd_lo = 1'b0;
        check("R3 priority data", 32'(rd_data), 32'h1234);
        check("R3 priority pop", 32'(stat_rdata[15:6]), 0);

        // R9 default threshold of 256
        stat_write(2'b01, 16'h0001);
        check("R9 enable readback", 32'(stat_rdata[0]), 1);
        for (int i = 0; i < 255; i++) do_push(16'(i), 5'(i % 16));
        check("R9 below default", 32'(irq), 0);
        do_push(16'd255, 5'd15);
        check("R1 R9 default threshold reached", 32'(irq), 1);
        stat_write(2'b01, 16'h0000);
        check("R9 disable", 32'(irq), 0);
        stat_write(2'b01, 16'h0001);
        check("R9 re-enable", 32'(irq), 1);

        // R7 fill to full and drop
        for (int i = 256; i < 512; i++) do_push(16'(i), 5'(i % 16));
        check("R7 full flag", 32'(full), 1);
        check("R7 count full", 32'(stat_rdata[15:6]), 512);
        do_push(16'hDEAD, 5'd9);
        check("R7 dropped push", 32'(stat_rdata[15:6]), 512);
        check("R6 head at full", 32'(stat_rdata[5:1]), 0);
        do_read(1);
        check("R7 first sample kept", 32'(rd_data), 0);
        check("R7 full cleared", 32'(full), 0);

        // R11 push and pop together
        push = 1'b1; push_data = 16'hBEEF; push_tag = 5'd2; rd_word = 1'b1;
        step();
        push = 1'b0; rd_word = 1'b0;
        check("R11 count stable", 32'(stat_rdata[15:6]), 511);
        check("R11 read data", 32'(rd_data), 1);

        // R9 threshold boundaries at count 511
        stat_write(2'b10, {10'd600, 6'd0});
        check("R9 above count", 32'(irq), 0);
        stat_write(2'b10, {10'd511, 6'd0});
        check("R9 equal count", 32'(irq), 1);
        stat_write(2'b10, {10'd512, 6'd0});
        check("R9 one above", 32'(irq), 0);
        check("R9 mask keeps enable", 32'(stat_rdata[0]), 1);

        // R10 flush wins over push
        flush = 1'b1; push = 1'b1; push_data = 16'h7777;
        step();
        flush = 1'b0; push = 1'b0;
        check("R10 flush count", 32'(stat_rdata[15:6]), 0);
        check("R10 flush full", 32'(full), 0);

        // R8 empty read returns last popped sample
        do_read(1);
        check("R8 empty word read", 32'(rd_data), 1);
        check("R8 empty tag", 32'(stat_rdata[5:1]), 1);
        check("R8 empty count", 32'(stat_rdata[15:6]), 0);

        // R9 threshold zero
        stat_write(2'b10, 16'h0000);
        check("R9 zero threshold", 32'(irq), 1);

        done = 1;
        finish_run();
    end

endmodule